// File: doc/BRIEF.md
# Legacy I/O Port Address Router

This block turns a request aimed at the internal I/O port space into a tagged physical address for the memory system. Each request carries a port number, an access size in bytes and a write flag. One clock edge later the block returns three things: a target class, the physical address and a flag that marks the access as uncacheable and strictly ordered.

The block holds the 32-bit configuration-address register of the two-port indirect PCI configuration mechanism. A 4-byte access to port 0xCF8 selects that register, and a 4-byte write to it loads a new value. Accesses to ports 0xCFC through 0xCFF are configuration data accesses. When bit 31 of the register is set, such an access goes to PCI configuration space at a dword address taken from register bits 30:2. When bit 31 is clear, it falls through to ordinary I/O. Port numbers wider than 16 bits are reported as an error.

Top module: `io_port_router`

## Requirements
- R1: After reset, `rsp_valid` is 0 and the configuration-address register (`cfg_value`) reads 0.
- R2: A request whose port has any bit at or above bit 16 set returns `rsp_err`=1, target code 0 (none), address 0 and `rsp_uc`=0.
- R3: A request with size 4 to port 0xCF8 returns target code 1 (configuration-address register) with address `CFGREG_ADDR`.
- R4: A write request with size 4 to port 0xCF8 loads `req_wdata` into the register, and the new value shows on `cfg_value` after that edge. No other request changes the register, including a write of another size to 0xCF8.
- R5: A request to port 0xCF8 with a size other than 4 is a plain I/O access: target code 3, address `IO_PREFIX` | port.
- R6: A request to ports 0xCFC–0xCFF while register bit 31 is 1 returns target code 2. Its address is `CFG_PREFIX` | {register bits 30:2, 2'b00} | port bits 1:0.
- R7: A request to ports 0xCFC–0xCFF while register bit 31 is 0 returns target code 3 with address `IO_PREFIX` | port.
- R8: Any other 16-bit port returns target code 3 with address `IO_PREFIX` | port.
- R9: `rsp_uc` is 1 for target codes 2 and 3 and 0 for codes 0 and 1.
- R10: The response is registered. `rsp_valid` in a cycle equals `req_valid` of the previous cycle, and a configuration data access uses the register value held before any write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_port | input | PORT_IN_W (32) | Port number, only the low 16 bits legal |
| req_size | input | SIZE_W (4) | Access size in bytes |
| req_write | input | 1 | Request is a write |
| req_wdata | input | 32 | Write data for the configuration-address register |
| rsp_valid | output | 1 | Response present |
| rsp_err | output | 1 | Port number out of range |
| rsp_tgt | output | 2 | Target: 0 none, 1 config-address register, 2 PCI config, 3 I/O |
| rsp_paddr | output | PA_W (64) | Resulting physical address |
| rsp_uc | output | 1 | Uncacheable and strictly ordered |
| cfg_value | output | 32 | Current configuration-address register value |

## Verification
A corrupted configuration-address register does not show on the next response. It shows on the first configuration data access after it: that access goes to I/O instead of configuration space, or the reverse, or it carries a wrong dword address. For this reason every register value in the sweep is followed at once by data accesses to all four data ports, and the register is also compared directly on `cfg_value`. A decode fault in the port classifier shows within one cycle as a wrong target code or prefix, so the sweeps cover every port near 0xCF8–0xCFF at each size and a strided pass across the whole 16-bit space.

// File: rtl/io_route_pkg.sv
package io_route_pkg;

    localparam int IO_PORT_W   = 16;
    localparam int CFG_REG_W   = 32;
    localparam logic [IO_PORT_W-1:0] CFG_ADDR_PORT = 16'h0CF8;
    localparam logic [IO_PORT_W-1:0] CFG_DATA_BASE = 16'h0CFC;
    localparam int CFG_ADDR_SIZE = 4;
    localparam int CFG_EN_BIT    = 31;

    // decoded class of a request before the register is consulted
    typedef enum logic [1:0] {
        CLS_BAD    = 2'd0,
        CLS_CFGREG = 2'd1,
        CLS_CFGDAT = 2'd2,
        CLS_PLAIN  = 2'd3
    } io_class_e;

    // final target reported on the response
    typedef enum logic [1:0] {
        TGT_NONE   = 2'd0,
        TGT_CFGREG = 2'd1,
        TGT_PCICFG = 2'd2,
        TGT_IO     = 2'd3
    } io_tgt_e;

    typedef struct packed {
        io_tgt_e tgt;
        logic    err;
        logic    uc;
    } io_route_t;

    function automatic logic hits_cfg_data(input logic [IO_PORT_W-1:0] p);
        return {p[IO_PORT_W-1:2], 2'b00} == CFG_DATA_BASE;
    endfunction

    function automatic logic hits_cfg_addr(input logic [IO_PORT_W-1:0] p);
        return p == CFG_ADDR_PORT;
    endfunction

    function automatic logic tgt_is_uc(input io_tgt_e t);
        return (t == TGT_PCICFG) || (t == TGT_IO);
    endfunction

endpackage

// File: rtl/io_port_classify.sv
module io_port_classify
    import io_route_pkg::*;
#(
    parameter int PORT_IN_W = 32,
    parameter int SIZE_W    = 4
) (
    input  logic [PORT_IN_W-1:0] port_in,
    input  logic [SIZE_W-1:0]    size_in,
    output io_class_e            cls,
    output logic [IO_PORT_W-1:0] port16
);
    logic over;

    generate
        if (PORT_IN_W > IO_PORT_W) begin : g_wide
            assign over = |port_in[PORT_IN_W-1:IO_PORT_W];
        end else begin : g_narrow
            assign over = 1'b0;
        end
    endgenerate

    assign port16 = port_in[IO_PORT_W-1:0];

    always_comb begin
        if (over) begin
            cls = CLS_BAD;
        end else if (hits_cfg_addr(port16) &&
                     size_in == SIZE_W'(CFG_ADDR_SIZE)) begin
            cls = CLS_CFGREG;
        end else if (hits_cfg_data(port16)) begin
            cls = CLS_CFGDAT;
        end else begin
            cls = CLS_PLAIN;
        end
    end
endmodule

// File: rtl/io_cfg_addr_reg.sv
module io_cfg_addr_reg
    import io_route_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [CFG_REG_W-1:0] wdata,
    output logic [CFG_REG_W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (wr_en) begin
            q <= wdata;
        end
    end
endmodule

// File: rtl/io_paddr_build.sv
module io_paddr_build
    import io_route_pkg::*;
#(
    parameter int                PA_W        = 64,
    parameter logic [PA_W-1:0]   CFG_PREFIX  = 64'h0000_0002_0000_0000,
    parameter logic [PA_W-1:0]   IO_PREFIX   = 64'h0000_0001_0000_0000,
    parameter logic [PA_W-1:0]   CFGREG_ADDR = 64'h0000_0004_0000_0000
) (
    input  io_class_e            cls,
    input  logic [IO_PORT_W-1:0] port16,
    input  logic [CFG_REG_W-1:0] cfg_q,
    output io_route_t            route,
    output logic [PA_W-1:0]      paddr
);
    localparam int PAD_PORT = PA_W - IO_PORT_W;
    localparam int PAD_CFG  = PA_W - CFG_EN_BIT;

    logic [PA_W-1:0] io_addr;
    logic [PA_W-1:0] cfg_addr;

    assign io_addr  = IO_PREFIX | {{PAD_PORT{1'b0}}, port16};
    assign cfg_addr = CFG_PREFIX
                    | {{PAD_CFG{1'b0}}, cfg_q[CFG_EN_BIT-1:2], 2'b00}
                    | {{(PA_W-2){1'b0}}, port16[1:0]};

    always_comb begin
        route.err = 1'b0;
        route.tgt = TGT_IO;
        paddr     = io_addr;
        unique case (cls)
            CLS_BAD: begin
                route.err = 1'b1;
                route.tgt = TGT_NONE;
                paddr     = '0;
            end
            CLS_CFGREG: begin
                route.tgt = TGT_CFGREG;
                paddr     = CFGREG_ADDR;
            end
            CLS_CFGDAT: begin
                if (cfg_q[CFG_EN_BIT]) begin
                    route.tgt = TGT_PCICFG;
                    paddr     = cfg_addr;
                end
            end
            default: begin
                route.tgt = TGT_IO;
                paddr     = io_addr;
            end
        endcase
        route.uc = tgt_is_uc(route.tgt);
    end
endmodule

// File: rtl/io_port_router.sv
module io_port_router
    import io_route_pkg::*;
#(
    parameter int              PORT_IN_W   = 32,
    parameter int              SIZE_W      = 4,
    parameter int              PA_W        = 64,
    parameter logic [PA_W-1:0] CFG_PREFIX  = 64'h0000_0002_0000_0000,
    parameter logic [PA_W-1:0] IO_PREFIX   = 64'h0000_0001_0000_0000,
    parameter logic [PA_W-1:0] CFGREG_ADDR = 64'h0000_0004_0000_0000
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    input  logic [PORT_IN_W-1:0] req_port,
    input  logic [SIZE_W-1:0]    req_size,
    input  logic                 req_write,
    input  logic [31:0]          req_wdata,
    output logic                 rsp_valid,
    output logic                 rsp_err,
    output logic [1:0]           rsp_tgt,
    output logic [PA_W-1:0]      rsp_paddr,
    output logic                 rsp_uc,
    output logic [31:0]          cfg_value
);
    io_class_e            cls;
    logic [IO_PORT_W-1:0] port16;
    io_route_t            route_c;
    io_route_t            route_q;
    logic [PA_W-1:0]      paddr_c;
    logic [PA_W-1:0]      paddr_q;
    logic                 valid_q;
    logic                 cfg_wr;
    logic [CFG_REG_W-1:0] cfg_q;

    io_port_classify #(.PORT_IN_W(PORT_IN_W), .SIZE_W(SIZE_W)) u_cls (
        .port_in (req_port),
        .size_in (req_size),
        .cls     (cls),
        .port16  (port16)
    );

    assign cfg_wr = req_valid && req_write && (cls == CLS_CFGREG);

    io_cfg_addr_reg u_reg (
        .clk   (clk),
        .rst   (rst),
        .wr_en (cfg_wr),
        .wdata (req_wdata),
        .q     (cfg_q)
    );

    io_paddr_build #(
        .PA_W(PA_W), .CFG_PREFIX(CFG_PREFIX),
        .IO_PREFIX(IO_PREFIX), .CFGREG_ADDR(CFGREG_ADDR)
    ) u_build (
        .cls    (cls),
        .port16 (port16),
        .cfg_q  (cfg_q),
        .route  (route_c),
        .paddr  (paddr_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            route_q <= '{tgt: TGT_NONE, err: 1'b0, uc: 1'b0};
            paddr_q <= '0;
        end else begin
            valid_q <= req_valid;
            if (req_valid) begin
                route_q <= route_c;
                paddr_q <= paddr_c;
            end
        end
    end

    assign rsp_valid = valid_q;
    assign rsp_err   = route_q.err;
    assign rsp_tgt   = route_q.tgt;
    assign rsp_paddr = paddr_q;
    assign rsp_uc    = route_q.uc;
    assign cfg_value = cfg_q;

    // R10
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    // R10
    rsp_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);

    // R2
    bad_port_err_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_port[PORT_IN_W-1:IO_PORT_W] != '0)
        |=> (rsp_err && rsp_tgt == TGT_NONE && !rsp_uc));

    // R4
    cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(req_valid && req_write && req_port == PORT_IN_W'(CFG_ADDR_PORT)
          && req_size == SIZE_W'(CFG_ADDR_SIZE)) |=> $stable(cfg_value));

    // R9
    uc_class_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_tgt[1]) |-> rsp_uc);

    // R6
    pci_prefix_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_tgt == TGT_PCICFG)
        |-> ((rsp_paddr & ~PA_W'(32'h7FFF_FFFF)) == CFG_PREFIX));
endmodule

// File: tb/io_port_router_tb.sv
module io_port_router_tb;
    localparam logic [63:0] CFGP = 64'h0000_0002_0000_0000;
    localparam logic [63:0] IOP  = 64'h0000_0001_0000_0000;
    localparam logic [63:0] REGA = 64'h0000_0004_0000_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [31:0] req_port = '0;
    logic [3:0]  req_size = '0;
    logic        req_write = 1'b0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid, rsp_err, rsp_uc;
    logic [1:0]  rsp_tgt;
    logic [63:0] rsp_paddr;
    logic [31:0] cfg_value;

    int errors = 0;
    int checks = 0;
    logic [31:0] model = '0;
    bit done = 0;

    always #4 clk = ~clk;

    io_port_router u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_port(req_port),
        .req_size(req_size), .req_write(req_write), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_tgt(rsp_tgt),
        .rsp_paddr(rsp_paddr), .rsp_uc(rsp_uc), .cfg_value(cfg_value)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic access(input logic [31:0] p, input logic [3:0] sz,
                          input bit wr, input logic [31:0] wd);
        logic [63:0] e_pa;
        logic [1:0]  e_tgt;
        bit          e_err;
        string       tag;
        @(negedge clk);
        req_valid = 1'b1; req_port = p; req_size = sz;
        req_write = wr;   req_wdata = wd;
        e_err = 0;
        if (p[31:16] != 0) begin
            e_err = 1; e_tgt = 2'd0; e_pa = '0; tag = "R2";
        end else if (p == 32'hCF8 && sz == 4) begin
            e_tgt = 2'd1; e_pa = REGA; tag = "R3";
        end else if (p >= 32'hCFC && p <= 32'hCFF) begin
            if (model[31]) begin
                e_tgt = 2'd2; tag = "R6";
                e_pa = CFGP | {32'h0, model & 32'h7FFF_FFFC} | {62'h0, p[1:0]};
            end else begin
                e_tgt = 2'd3; e_pa = IOP | {32'h0, p}; tag = "R7";
            end
        end else begin
            e_tgt = 2'd3; e_pa = IOP | {32'h0, p};
            tag = (p == 32'hCF8) ? "R5" : "R8";
        end
        @(posedge clk);
        #1;
        req_valid = 1'b0;
        chk(rsp_valid === 1'b1, "R10", "valid", {63'h0, rsp_valid}, 64'h1);
        chk(rsp_err === e_err && rsp_tgt === e_tgt && rsp_paddr === e_pa,
            tag, "target/addr", {rsp_err, rsp_tgt, rsp_paddr[60:0]},
            {e_err, e_tgt, e_pa[60:0]});
        chk(rsp_uc === e_tgt[1], "R9", "uc", {63'h0, rsp_uc}, {63'h0, e_tgt[1]});
        if (wr && p == 32'hCF8 && sz == 4) model = wd;
        chk(cfg_value === model, "R4", "cfg_value", {32'h0, cfg_value},
            {32'h0, model});
    endtask

    initial begin
        #1_500_000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] vals [5];
        vals[0] = 32'h0000_0000; vals[1] = 32'h8000_1234;
        vals[2] = 32'hFFFF_FFFF; vals[3] = 32'h7FFF_FFFF;
        vals[4] = 32'h8ABC_DEF0;
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        chk(rsp_valid === 1'b0, "R1", "valid", {63'h0, rsp_valid}, 64'h0);
        chk(cfg_value === 32'h0, "R1", "cfg", {32'h0, cfg_value}, 64'h0);
        @(negedge clk);
        rst = 1'b0;
        // R7 data access right after reset: enable bit clear
        access(32'hCFC, 4, 0, 0);
        for (int v = 0; v < 5; v++) begin
            access(32'hCF8, 4, 1, vals[v]);
            for (int p = 32'hCF0; p < 32'hD08; p++)
                for (int s = 1; s <= 4; s = s * 2)
                    access(p, s[3:0], 0, 32'h0);
        end
        // R4: writes of other sizes to 0xCF8 leave the register alone
        access(32'hCF8, 2, 1, 32'h1234_5678);
        access(32'hCF8, 1, 1, 32'h0);
        access(32'hCFE, 1, 0, 0);
        // R4/R10: write then immediate data access sees new value
        access(32'hCF8, 4, 1, 32'h8000_0F04);
        access(32'hCFF, 1, 0, 0);
        access(32'hCF8, 4, 1, 32'h0000_0F04);
        access(32'hCFD, 2, 0, 0);
        // R2 out-of-range ports, including a write that must not land
        access(32'h0001_0000, 4, 0, 0);
        access(32'h8000_0CFC, 4, 0, 0);
        access(32'h0001_0CF8, 4, 1, 32'hDEAD_BEEF);
        access(32'hFFFF_FFFF, 1, 0, 0);
        // R8 strided sweep over the 16-bit space
        for (int p = 0; p < 32'h10000; p += 7)
            access(p, 1, 0, 0);
        access(32'hFFFF, 2, 0, 0);
        // R10 idle cycle
        @(negedge clk);
        @(posedge clk);
        #1;
        chk(rsp_valid === 1'b0, "R10", "idle", {63'h0, rsp_valid}, 64'h0);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule